// File: doc/BRIEF.md
# External Bus Cycle Controller

This block sits between a CPU-side request port and a narrow external system bus. The bus has a 16-bit data path and a 24-bit byte address. The CPU presents one request at a time: a byte, halfword or word data access, or an instruction fetch of one to four words. The controller turns it into one or more bus beats. A word becomes two halfword beats, upper half first. Each beat opens with a one-cycle start strobe. The beat then stretches until the slave pulls the completion input low.

Some patterns get special treatment. A write that arrives straight after a read gets an extra idle cycle, so that the two data drivers never overlap on the bus. An aligned word read, or a fetch that starts on a 16-byte boundary, is flagged as a burst during its first beat. Read data returns to the CPU one 32-bit word at a time as each word completes. The request is granted in the cycle in which its final beat completes.

Top module: `extBusCtl`

## Requirements
- R1: While reset is asserted and afterwards until a request is accepted, the start strobe, burst flag and both lane strobes are high, the data output enable and grant are low, and direction reads high (read).
- R2: A request presented while the controller is idle starts its first beat in the next cycle. Each beat drives the start strobe low in its first cycle only.
- R3: A beat lasts until busDcN is sampled low at a rising clock edge. During the wait cycles before that edge, the address, direction and strobes are held and no new start is driven.
- R4: A word access (reqSize 2) runs as two beats, at the request address and then at the address plus 2. A fetch (reqFetch high, reqWords = word count minus 1) runs as 2 x count beats at consecutive even addresses. Byte (reqSize 0) and halfword (reqSize 1) accesses take one beat.
- R5: reqGrant is high, combinationally, in the cycle whose rising edge completes the final beat. The next cycle is idle on the bus.
- R6: A write presented in the cycle right after a read or fetch was granted waits one extra idle cycle, so its first beat starts two cycles after it is presented. A write presented later than that, and any read, gets no extra cycle.
- R7: busBurstN is low for the whole first beat, and only that beat, of a word data read whose address has bits [1:0] zero, or of a fetch whose address has bits [3:0] zero. It is never low on writes.
- R8: On write beats, byte writes pull low only the lane of the addressed byte: busUbN (data bits 15:8) for an even address, busLbN (bits 7:0) for an odd one. Halfword and word writes pull both lanes low. On read beats both lanes stay high.
- R9: On write beats busDataOe is high and busDataOut carries reqWdata[31:16] and then [15:0] for a word, [15:0] for a halfword, and reqWdata[7:0] copied onto both lanes for a byte.
- R10: rdValid pulses with rdData as each read word completes. A word is the first beat's halfword above the second beat's. A halfword is zero-extended. A byte is taken from bits 15:8 for an even address and from bits 7:0 for an odd one, zero-extended.
- R11: busRdWrN is low exactly on write beats, and busDataOe is never high while busRdWrN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until granted |
| reqGrant | output | 1 | Request finished this cycle |
| reqWrite | input | 1 | Data write when high (ignored for fetches) |
| reqFetch | input | 1 | Instruction fetch request |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWords | input | 2 | Fetch word count minus one |
| reqAddr | input | 24 | Byte address |
| reqWdata | input | 32 | Write data |
| rdValid | output | 1 | Read word returned this cycle |
| rdData | output | 32 | Returned read word |
| busAddr | output | 24 | Bus address of the current beat |
| busDataOut | output | 16 | Bus write data |
| busDataOe | output | 1 | Bus data driver enable |
| busDataIn | input | 16 | Bus read data |
| busStartN | output | 1 | Beat start strobe, active low |
| busRdWrN | output | 1 | High for read, low for write |
| busUbN | output | 1 | Upper byte lane strobe, active low |
| busLbN | output | 1 | Lower byte lane strobe, active low |
| busBurstN | output | 1 | Burst flag, active low |
| busDcN | input | 1 | Slave completion, active low |

## Verification
Directed accesses come first. They include aligned and misaligned word reads and fetches, so that burst and plain transfers can be told apart. Byte writes and reads at even and odd addresses separate the two lanes. Write-after-read pairs are run with no gap and with a one-cycle gap, which shows whether the turnaround cycle is added only when required. Random accesses with random slave wait counts (zero to three) and random gaps follow. They show that the beat count, address stepping, data placement and grant timing stay correct however long the slave stretches each beat.

// File: rtl/extBusPkg.sv
package extBusPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_BEAT = 2'd2
  } seqState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // move to the next beat
    logic capHi;  // keep the upper read halfword
  } dpCtl_t;

endpackage

// File: rtl/extBusSeq.sv
module extBusSeq
  import extBusPkg::*;
#(
  parameter int MAX_WORDS = 4,
  localparam int WCNT_W = $clog2(MAX_WORDS),
  localparam int ALIGN_W = WCNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [1:0]        reqSize,
  input  logic [WCNT_W-1:0] reqWords,
  input  logic [ALIGN_W-1:0] reqAddrLow,
  input  logic              busDcN,
  output logic              reqGrant,
  output logic              rdValid,
  output logic              busStartN,
  output logic              busBurstN,
  output logic              beatOn,
  output dpCtl_t            dpCtl
);

  localparam int BEAT_W = WCNT_W + 1;

  seqState_e       state;
  logic [BEAT_W-1:0] beatIdx, beatLast;
  logic            startCyc, burstOn, curWrite, multiBeat, prevRead;

  logic            isWriteReq, burstOk, needTurn, loadNow, beatDone, lastBeat;
  logic [BEAT_W-1:0] beatsM1;

  always_comb begin
    isWriteReq = reqWrite && !reqFetch;
    if (reqFetch)
      beatsM1 = {reqWords, 1'b1};
    else if (accSize_e'(reqSize) == SZ_WORD)
      beatsM1 = BEAT_W'(1);
    else
      beatsM1 = '0;
    if (reqFetch)
      burstOk = (reqAddrLow == '0);
    else
      burstOk = !reqWrite && (accSize_e'(reqSize) == SZ_WORD) && (reqAddrLow[1:0] == 2'b00);
    needTurn = isWriteReq && prevRead;
    loadNow  = ((state == ST_IDLE) && reqValid && !needTurn) || (state == ST_TURN);
    beatOn   = (state == ST_BEAT);
    beatDone = beatOn && !busDcN;
    lastBeat = (beatIdx == beatLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatIdx   <= '0;
      beatLast  <= '0;
      startCyc  <= 1'b0;
      burstOn   <= 1'b0;
      curWrite  <= 1'b0;
      multiBeat <= 1'b0;
      prevRead  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          prevRead <= 1'b0;
          if (reqValid) state <= needTurn ? ST_TURN : ST_BEAT;
        end
        ST_TURN: begin
          prevRead <= 1'b0;
          state    <= ST_BEAT;
        end
        ST_BEAT: begin
          startCyc <= 1'b0;
          if (beatDone) begin
            burstOn <= 1'b0;
            if (lastBeat) begin
              state    <= ST_IDLE;
              prevRead <= !curWrite;
            end else begin
              beatIdx  <= beatIdx + BEAT_W'(1);
              startCyc <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (loadNow) begin
        beatIdx   <= '0;
        beatLast  <= beatsM1;
        startCyc  <= 1'b1;
        burstOn   <= burstOk;
        curWrite  <= isWriteReq;
        multiBeat <= (beatsM1 != '0);
      end
    end
  end

  assign busStartN = !(beatOn && startCyc);
  assign busBurstN = !(beatOn && burstOn);
  assign reqGrant  = beatDone && lastBeat;
  assign rdValid   = beatDone && !curWrite && (!multiBeat || beatIdx[0]);

  always_comb begin
    dpCtl.load  = loadNow;
    dpCtl.step  = beatDone && !lastBeat;
    dpCtl.capHi = beatDone && !curWrite && multiBeat && !beatIdx[0];
  end

endmodule

// File: rtl/extBusPath.sv
module extBusPath
  import extBusPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16,
  localparam int WORD_W = 2 * BUS_W,
  localparam int BYTE_W = BUS_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              beatOn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [BUS_W-1:0]  busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  busDataOut,
  output logic              busDataOe,
  output logic              busRdWrN,
  output logic              busUbN,
  output logic              busLbN,
  output logic [WORD_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] wdReg;
  accSize_e          sizeReg;
  logic              wrReg, lowHalf;
  logic [BUS_W-1:0]  hiReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wdReg   <= '0;
      sizeReg <= SZ_BYTE;
      wrReg   <= 1'b0;
      lowHalf <= 1'b0;
      hiReg   <= '0;
    end else begin
      if (dpCtl.load) begin
        addrReg <= reqAddr;
        wdReg   <= reqWdata;
        sizeReg <= reqFetch ? SZ_WORD : accSize_e'(reqSize);
        wrReg   <= reqWrite && !reqFetch;
        lowHalf <= 1'b0;
      end else if (dpCtl.step) begin
        addrReg <= addrReg + ADDR_W'(2);
        lowHalf <= !lowHalf;
      end
      if (dpCtl.capHi) hiReg <= busDataIn;
    end
  end

  logic wrBeat;
  assign wrBeat    = beatOn && wrReg;
  assign busAddr   = addrReg;
  assign busRdWrN  = !wrBeat;
  assign busDataOe = wrBeat;

  always_comb begin
    case (sizeReg)
      SZ_WORD: busDataOut = lowHalf ? wdReg[BUS_W-1:0] : wdReg[WORD_W-1:BUS_W];
      SZ_HALF: busDataOut = wdReg[BUS_W-1:0];
      default: busDataOut = {wdReg[BYTE_W-1:0], wdReg[BYTE_W-1:0]};
    endcase
    busUbN = 1'b1;
    busLbN = 1'b1;
    if (wrBeat) begin
      if (sizeReg == SZ_BYTE) begin
        busUbN = addrReg[0];
        busLbN = !addrReg[0];
      end else begin
        busUbN = 1'b0;
        busLbN = 1'b0;
      end
    end
    case (sizeReg)
      SZ_WORD: rdData = {hiReg, busDataIn};
      SZ_HALF: rdData = {{BUS_W{1'b0}}, busDataIn};
      default: rdData = {{(WORD_W-BYTE_W){1'b0}},
                         addrReg[0] ? busDataIn[BYTE_W-1:0] : busDataIn[BUS_W-1:BYTE_W]};
    endcase
  end

endmodule

// File: rtl/extBusCtl.sv
module extBusCtl
  import extBusPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BUS_W     = 16,
  parameter int MAX_WORDS = 4,
  localparam int WCNT_W = $clog2(MAX_WORDS),
  localparam int WORD_W = 2 * BUS_W,
  localparam int ALIGN_W = WCNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqGrant,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [1:0]        reqSize,
  input  logic [WCNT_W-1:0] reqWords,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  busDataOut,
  output logic              busDataOe,
  input  logic [BUS_W-1:0]  busDataIn,
  output logic              busStartN,
  output logic              busRdWrN,
  output logic              busUbN,
  output logic              busLbN,
  output logic              busBurstN,
  input  logic              busDcN
);

  dpCtl_t dpCtl;
  logic   beatOn;

  extBusSeq #(.MAX_WORDS(MAX_WORDS)) u_seq (
    .clk, .rstN, .reqValid, .reqWrite, .reqFetch, .reqSize, .reqWords,
    .reqAddrLow(reqAddr[ALIGN_W-1:0]), .busDcN,
    .reqGrant, .rdValid, .busStartN, .busBurstN, .beatOn, .dpCtl
  );

  extBusPath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_path (
    .clk, .rstN, .dpCtl, .beatOn, .reqAddr, .reqWdata, .reqSize, .reqWrite,
    .reqFetch, .busDataIn, .busAddr, .busDataOut, .busDataOe, .busRdWrN,
    .busUbN, .busLbN, .rdData
  );

endmodule

// File: rtl/extBusCtlChk.sv
module extBusCtlChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              beatOn,
  input logic              busStartN,
  input logic              busDcN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdWrN,
  input logic              busUbN,
  input logic              busLbN,
  input logic              busBurstN,
  input logic              busDataOe,
  input logic              reqGrant
);

  // R2
  wait_nostart_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOn && busDcN |=> busStartN);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOn && busDcN |=> beatOn && $stable(busAddr) && $stable(busRdWrN)
                         && $stable(busUbN) && $stable(busLbN));

  // R4
  step_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOn && !busDcN && !reqGrant |=> !busStartN && busAddr == $past(busAddr) + ADDR_W'(2));

  // R5
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |=> busStartN && !beatOn);

  // R6
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant && busRdWrN |=> ##1 (busRdWrN || busStartN));

  // R7
  burst_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busBurstN |-> busRdWrN && beatOn);

  // R7
  burst_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOn && !busDcN && !reqGrant |=> busBurstN);

  // R8
  lane_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOn && busRdWrN |-> busUbN && busLbN);

  // R11
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> !busRdWrN);

endmodule

bind extBusCtl extBusCtlChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rstN, .beatOn, .busStartN, .busDcN, .busAddr, .busRdWrN,
  .busUbN, .busLbN, .busBurstN, .busDataOe, .reqGrant
);

// File: tb/extBusCtl_test.sv
module extBusCtl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqFetch = 1'b0;
  logic [1:0]  reqSize = 2'd0, reqWords = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqGrant, rdValid;
  logic [31:0] rdData;
  logic [23:0] busAddr;
  logic [15:0] busDataOut, busDataIn = '0;
  logic        busDataOe, busStartN, busRdWrN, busUbN, busLbN, busBurstN;
  logic        busDcN = 1'b1;

  extBusCtl uut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and beat log
  logic [23:0] lgAddr[16];
  logic [15:0] lgData[16];
  logic        lgRw[16], lgUb[16], lgLb[16], lgBurst[16], lgOe[16];
  int          lgCyc[16];
  int          logN = 0, waitLeft = 0, maxWait = 3;
  bit          inBeat = 0;

  function automatic logic [15:0] memHalf(input logic [23:0] a);
    return a[16:1] ^ 16'hA55A ^ {a[8:1], a[23:16]};
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      busDcN = 1'b1; inBeat = 0;
    end else begin
      if (!busStartN) begin
        if (logN < 16) begin
          lgAddr[logN] = busAddr; lgData[logN] = busDataOut; lgRw[logN] = busRdWrN;
          lgUb[logN] = busUbN; lgLb[logN] = busLbN; lgBurst[logN] = busBurstN;
          lgOe[logN] = busDataOe; lgCyc[logN] = cyc;
        end
        logN++;
        waitLeft = $urandom_range(0, maxWait);
        inBeat = 1;
      end
      busDataIn = memHalf(busAddr);
      if (inBeat) begin
        if (waitLeft == 0) begin busDcN = 1'b0; inBeat = 0; end
        else begin busDcN = 1'b1; waitLeft--; end
      end else busDcN = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit burstExp(input bit wr, input bit fe, input logic [1:0] sz,
                                  input logic [23:0] a);
    if (fe) return a[3:0] == 4'd0;
    return !wr && sz == 2'd2 && a[1:0] == 2'b00;
  endfunction

  bit lastRead = 0;
  int lastGrantCyc = -10;

  task automatic runTxn(input bit wr, input bit fe, input logic [1:0] sz,
                        input logic [1:0] nw, input logic [23:0] a,
                        input logic [31:0] wd, input int gap);
    int nBeats, nWords, presentCyc, guard, rdN;
    logic [31:0] rdGot[4];
    bit isWr, turn, bexp;
    logic [31:0] expW;
    logic [15:0] expD;
    logic [7:0]  bt;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    isWr = wr && !fe;
    nBeats = fe ? 2 * (nw + 1) : (sz == 2'd2 ? 2 : 1);
    nWords = isWr ? 0 : (fe ? nw + 1 : 1);
    logN = 0; rdN = 0;
    reqValid = 1; reqWrite = wr; reqFetch = fe; reqSize = sz; reqWords = nw;
    reqAddr = a; reqWdata = wd;
    presentCyc = cyc;
    turn = isWr && lastRead && (presentCyc == lastGrantCyc + 1);
    guard = 0;
    while (1) begin
      #2;
      if (rdValid && rdN < 4) begin rdGot[rdN] = rdData; rdN++; end
      if (reqGrant) break;
      guard++;
      if (guard > 80) break;
      @(negedge clk);
    end
    chk(guard <= 80, "R5", "grant seen", guard, 80);
    lastGrantCyc = cyc;
    reqValid = 0;
    lastRead = !isWr;
    // R4 beat count
    chk(logN == nBeats, "R4", "beat count", logN, nBeats);
    // R2 / R6 start delay
    if (logN > 0)
      chk(lgCyc[0] - presentCyc == (turn ? 2 : 1), turn ? "R6" : "R2", "start delay",
          lgCyc[0] - presentCyc, turn ? 2 : 1);
    bexp = burstExp(wr, fe, sz, a);
    for (int i = 0; i < nBeats && i < logN; i++) begin
      chk(lgAddr[i] == a + 24'(2 * i), "R4", "beat address", lgAddr[i], a + 24'(2 * i));
      chk(lgRw[i] == !isWr && lgOe[i] == isWr, "R11", "direction", {lgRw[i], lgOe[i]}, {!isWr, isWr});
      chk(lgBurst[i] == !(bexp && i == 0), "R7", "burst flag", lgBurst[i], !(bexp && i == 0));
      if (isWr) begin
        if (sz == 2'd0) begin
          chk(lgUb[i] == a[0] && lgLb[i] == !a[0], "R8", "byte lanes", {lgUb[i], lgLb[i]}, {a[0], !a[0]});
          expD = {wd[7:0], wd[7:0]};
        end else begin
          chk(!lgUb[i] && !lgLb[i], "R8", "both lanes", {lgUb[i], lgLb[i]}, 0);
          expD = (sz == 2'd2 && i == 0) ? wd[31:16] : wd[15:0];
        end
        chk(lgData[i] == expD, "R9", "write data", lgData[i], expD);
      end else
        chk(lgUb[i] && lgLb[i], "R8", "read lanes", {lgUb[i], lgLb[i]}, 2'b11);
    end
    chk(rdN == nWords, "R10", "read word count", rdN, nWords);
    for (int k = 0; k < nWords && k < rdN; k++) begin
      if (fe || sz == 2'd2)
        expW = {memHalf(a + 24'(4 * k)), memHalf(a + 24'(4 * k + 2))};
      else if (sz == 2'd1)
        expW = {16'h0, memHalf(a)};
      else begin
        bt = a[0] ? memHalf(a)[7:0] : memHalf(a)[15:8];
        expW = {24'h0, bt};
      end
      chk(rdGot[k] == expW, "R10", "read data", rdGot[k], expW);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL R5 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busStartN && busBurstN && busUbN && busLbN && !busDataOe && !reqGrant && busRdWrN,
        "R1", "reset outputs", {busStartN, busBurstN, busUbN, busLbN, busDataOe, reqGrant, busRdWrN},
        7'b1111001);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(busStartN && busBurstN && !busDataOe, "R1", "idle after reset",
        {busStartN, busBurstN, busDataOe}, 3'b110);

    // directed corner cases
    runTxn(0, 0, 2'd2, 0, 24'h000100, 0, 0);             // R7 aligned word read bursts
    runTxn(0, 0, 2'd2, 0, 24'h000102, 0, 0);             // R7 misaligned word read, no burst
    runTxn(1, 0, 2'd2, 0, 24'h000200, 32'hDEADBEEF, 0);  // R6 write right after read
    runTxn(0, 1, 2'd0, 2'd3, 24'h001000, 0, 0);          // R4 four-word aligned fetch
    runTxn(1, 0, 2'd0, 0, 24'h000301, 32'h000000A7, 0);  // R6 after fetch, R8 odd byte
    runTxn(1, 0, 2'd0, 0, 24'h000302, 32'h0000003C, 0);  // R8 even byte
    runTxn(0, 1, 2'd0, 2'd2, 24'h002008, 0, 0);          // R7 unaligned fetch, no burst
    runTxn(1, 0, 2'd1, 0, 24'h000400, 32'h00001234, 1);  // R6 gap, no turnaround
    runTxn(0, 0, 2'd0, 0, 24'h000501, 0, 0);             // R10 odd byte read
    runTxn(0, 0, 2'd0, 0, 24'h000500, 0, 0);             // R10 even byte read
    runTxn(0, 0, 2'd1, 0, 24'h000602, 0, 0);             // R10 halfword read
    maxWait = 0;
    runTxn(0, 0, 2'd2, 0, 24'h000700, 0, 0);             // R3 zero wait
    runTxn(1, 0, 2'd2, 0, 24'h000704, 32'h0BADF00D, 0);  // R6 zero wait
    maxWait = 3;

    // random mix
    for (int n = 0; n < 150; n++) begin
      bit w, f;
      logic [1:0] s;
      logic [23:0] ad;
      f  = ($urandom % 4) == 0;
      w  = !f && ($urandom % 2);
      s  = 2'($urandom % 3);
      ad = 24'($urandom);
      if (f) ad[3:1] = ($urandom % 2) ? 3'd0 : ad[3:1];
      if (f || s != 2'd0) ad[0] = 1'b0;
      if (!f && s == 2'd2 && ($urandom % 2)) ad[1] = 1'b0;
      runTxn(w, f, s, 2'($urandom % 4), ad, $urandom, $urandom % 2);
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule